// File: doc/BRIEF.md
# Processor Low-Power State Controller

This controller decides, for a processor core, which of three power states it is in: Running, Stop Grant or Sleep. From that state it drives a clock enable for each clock domain: the core units, the bus unit, the interrupt-controller unit and the PLL. It also drives two accept flags that say whether snoops and interrupts may be taken. On the way into Stop Grant it raises a one-cycle request so that the bus unit emits a stop-grant acknowledge transaction.

Three active-low asynchronous pins control the state: stop-clock, sleep and a reset pin. Each pin passes through a synchroniser before the state logic sees it. The hierarchy has two levels. Sleep can only be reached from Stop Grant, and the way back always passes through Stop Grant again.

The external bus clock is forwarded without gating in every state.

Top module: `lpc_ctrl`

## Requirements
- R1: While in Running, an asserted stop-clock pin (low) moves the controller to Stop Grant. `stpgnt_ack_req` is high for exactly one cycle, namely the first cycle in Stop Grant. It does not go high on any other transition.
- R2: In Stop Grant the core clock enable is 0. The bus, interrupt-controller and PLL enables are 1.
- R3: In Running and in Stop Grant, `snoop_accept` and `intr_accept` are both 1.
- R4: The sleep pin acts only in Stop Grant. When it is asserted (low) in Running, the state stays Running with all enables at 1.
- R5: In Sleep only `pll_en` is 1. The core, bus and interrupt-controller enables are 0.
- R6: In Sleep, `snoop_accept` and `intr_accept` are 0. Deasserting stop-clock while in Sleep leaves the state in Sleep.
- R7: In Sleep, deasserting the sleep pin (high) returns the controller to Stop Grant. This turns the bus and interrupt-controller enables back on.
- R8: In Stop Grant, a deasserted stop-clock pin returns the controller to Running with all four enables at 1.
- R9: `bus_clk_out` follows `bus_clk_in` combinationally in every state.
- R10: A pin change first affects the state and enables on the third rising clock edge after it (two synchroniser edges plus the state edge). Before that edge the outputs keep their old values.
- R11: A low reset pin (after synchronisation), or a high `rst`, forces Running with all enables at 1 and no acknowledge request. This holds even when stop-clock is asserted in the same cycle.
- R12: Leaving Sleep with stop-clock already deasserted passes through Stop Grant for exactly one cycle and then reaches Running.
- R13: `lp_state` encodes Running as 0, Stop Grant as 1 and Sleep as 2.
- R14: In Stop Grant, when stop-clock is deasserted and sleep is asserted in the same cycle, the controller goes to Running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| stop_n_pin | input | 1 | Asynchronous stop-clock request, active low |
| sleep_n_pin | input | 1 | Asynchronous sleep request, active low |
| reset_n_pin | input | 1 | Asynchronous reset pin, active low |
| bus_clk_in | input | 1 | External bus clock |
| bus_clk_out | output | 1 | Ungated copy of the bus clock |
| core_clk_en | output | 1 | Core-unit clock enable |
| bus_clk_en | output | 1 | Bus-unit clock enable |
| intc_clk_en | output | 1 | Interrupt-controller clock enable |
| pll_en | output | 1 | PLL enable |
| snoop_accept | output | 1 | Snoops may be accepted |
| intr_accept | output | 1 | Interrupts may be accepted |
| stpgnt_ack_req | output | 1 | One-cycle stop-grant acknowledge request |
| lp_state | output | 2 | Current state code |

## Verification
Two pairs of events can fall in the same cycle.

The first pair is entry into Stop Grant, with its acknowledge pulse, and a reset request. The bench provokes it by driving stop-clock and the reset pin low together in Running. It then expects Running with no pulse at the third edge.

The second pair is a stop-clock release and a sleep assertion arriving together in Stop Grant. The bench expects Running.

Both cases come out of an exhaustive sweep over every start state and all eight pin combinations. A bench model predicts the state for the third and the fourth edge, including the one-cycle pass through Stop Grant on the way out of Sleep.

// File: rtl/lpc_pkg.sv
package lpc_pkg;

    localparam int unsigned NUM_PINS = 3;

    typedef enum logic [1:0] {
        LP_RUN   = 2'd0,
        LP_GRANT = 2'd1,
        LP_SLEEP = 2'd2
    } lp_state_e;

    // synchronised requests, active high
    typedef struct packed {
        logic stop;
        logic sleep;
        logic hold;
    } pin_req_t;

    typedef struct packed {
        logic core;
        logic bus;
        logic intc;
        logic pll;
    } dom_en_t;

    function automatic dom_en_t dom_for(input lp_state_e s);
        dom_en_t e;
        e.pll  = 1'b1;
        e.core = (s == LP_RUN);
        e.bus  = (s != LP_SLEEP);
        e.intc = (s != LP_SLEEP);
        return e;
    endfunction

    function automatic logic accepts(input lp_state_e s);
        return s != LP_SLEEP;
    endfunction

endpackage

// File: rtl/lpc_sync.sv
module lpc_sync #(
    parameter int unsigned STAGES = 2,
    parameter int unsigned WIDTH  = 1,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= RST_VAL;
        else     chain[0] <= d;
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain[g] <= RST_VAL;
            else     chain[g] <= chain[g-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/lpc_fsm.sv
module lpc_fsm
    import lpc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  pin_req_t  req,
    output lp_state_e state,
    output logic      ack_req
);
    lp_state_e nxt;

    always_comb begin
        nxt = state;
        if (req.hold) begin
            nxt = LP_RUN;
        end else begin
            unique case (state)
                LP_RUN:   if (req.stop) nxt = LP_GRANT;
                LP_GRANT: begin
                    if (!req.stop)      nxt = LP_RUN;   // release wins over sleep
                    else if (req.sleep) nxt = LP_SLEEP;
                end
                LP_SLEEP: if (!req.sleep) nxt = LP_GRANT;
                default:  nxt = LP_RUN;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= LP_RUN;
            ack_req <= 1'b0;
        end else begin
            state   <= nxt;
            ack_req <= (state == LP_RUN) && (nxt == LP_GRANT);
        end
    end

    // R1: the acknowledge request is a single pulse
    p_ack_single_r1: assert property (@(posedge clk) disable iff (rst)
        ack_req |=> !ack_req);

    // R1: the pulse only appears together with Stop Grant
    p_ack_in_grant_r1: assert property (@(posedge clk) disable iff (rst)
        ack_req |-> state == LP_GRANT);

    // R4: Running never jumps straight into Sleep
    p_no_run_to_sleep_r4: assert property (@(posedge clk) disable iff (rst)
        state == LP_RUN |=> state != LP_SLEEP);

    // R12: without a reset, Sleep never jumps straight into Running
    p_sleep_via_grant_r12: assert property (@(posedge clk) disable iff (rst || req.hold)
        state == LP_SLEEP |=> state != LP_RUN);

    // R11: a synchronised reset request forces Running without a pulse
    p_hold_forces_run_r11: assert property (@(posedge clk) disable iff (rst)
        req.hold |=> (state == LP_RUN) && !ack_req);
endmodule

// File: rtl/lpc_domains.sv
module lpc_domains
    import lpc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  lp_state_e state,
    output dom_en_t   en,
    output logic      snoop_ok,
    output logic      intr_ok
);
    assign en       = dom_for(state);
    assign snoop_ok = accepts(state);
    assign intr_ok  = accepts(state);

    // R6: interrupts are taken only while the interrupt controller is clocked
    p_intr_needs_clock_r6: assert property (@(posedge clk) disable iff (rst)
        intr_ok |-> en.intc);

    // R5: whenever the bus clock stops, the core is stopped and the PLL runs
    p_sleep_pll_only_r5: assert property (@(posedge clk) disable iff (rst)
        !en.bus |-> (en.pll && !en.core && !snoop_ok));
endmodule

// File: rtl/lpc_ctrl.sv
module lpc_ctrl
    import lpc_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       stop_n_pin,
    input  logic       sleep_n_pin,
    input  logic       reset_n_pin,
    input  logic       bus_clk_in,
    output logic       bus_clk_out,
    output logic       core_clk_en,
    output logic       bus_clk_en,
    output logic       intc_clk_en,
    output logic       pll_en,
    output logic       snoop_accept,
    output logic       intr_accept,
    output logic       stpgnt_ack_req,
    output logic [1:0] lp_state
);
    logic [NUM_PINS-1:0] raw_req;
    logic [NUM_PINS-1:0] sync_req;
    pin_req_t            req;
    lp_state_e           state;
    dom_en_t             en;

    assign raw_req = {~stop_n_pin, ~sleep_n_pin, ~reset_n_pin};

    lpc_sync #(
        .STAGES (SYNC_STAGES),
        .WIDTH  (NUM_PINS),
        .RST_VAL('0)
    ) u_sync (
        .clk(clk),
        .rst(rst),
        .d  (raw_req),
        .q  (sync_req)
    );

    assign req = pin_req_t'(sync_req);

    lpc_fsm u_fsm (
        .clk    (clk),
        .rst    (rst),
        .req    (req),
        .state  (state),
        .ack_req(stpgnt_ack_req)
    );

    lpc_domains u_dom (
        .clk     (clk),
        .rst     (rst),
        .state   (state),
        .en      (en),
        .snoop_ok(snoop_accept),
        .intr_ok (intr_accept)
    );

    assign core_clk_en = en.core;
    assign bus_clk_en  = en.bus;
    assign intc_clk_en = en.intc;
    assign pll_en      = en.pll;
    assign lp_state    = state;
    assign bus_clk_out = bus_clk_in;   // never gated
endmodule

// File: tb/tb_lpc_ctrl.sv
`timescale 1ns/1ps
module tb_lpc_ctrl;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic stop_n = 1'b1, sleep_n = 1'b1, reset_n = 1'b1, bclk = 1'b0;
    logic bclk_o, core_en, bus_en, intc_en, pll_en, snoop_ok, intr_ok, ack;
    logic [1:0] st;
    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;   // 125 MHz

    lpc_ctrl dut (
        .clk(clk), .rst(rst), .stop_n_pin(stop_n), .sleep_n_pin(sleep_n),
        .reset_n_pin(reset_n), .bus_clk_in(bclk), .bus_clk_out(bclk_o),
        .core_clk_en(core_en), .bus_clk_en(bus_en), .intc_clk_en(intc_en),
        .pll_en(pll_en), .snoop_accept(snoop_ok), .intr_accept(intr_ok),
        .stpgnt_ack_req(ack), .lp_state(st)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // model: 0 run, 1 grant, 2 sleep (R13)
    function automatic int model(input int s, input bit sn, input bit pn, input bit rn);
        if (!rn) return 0;
        case (s)
            0: return sn ? 0 : 1;
            1: return sn ? 0 : (pn ? 1 : 2);   // R14: release wins
            default: return pn ? 1 : 2;
        endcase
    endfunction

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_state(input string ctx, input int s, input bit exp_ack);
        string t = (s == 0) ? "R8" : (s == 1) ? "R2" : "R5";
        string a = (s == 2) ? "R6" : "R3";
        chk({ctx, " R13 state"}, st, s);
        chk({ctx, " ", t, " core"}, core_en, s == 0);
        chk({ctx, " ", t, " bus"}, bus_en, s != 2);
        chk({ctx, " ", t, " intc"}, intc_en, s != 2);
        chk({ctx, " ", t, " pll"}, pll_en, 1);
        chk({ctx, " ", a, " snoop"}, snoop_ok, s != 2);
        chk({ctx, " ", a, " intr"}, intr_ok, s != 2);
        chk({ctx, " R1 ack"}, ack, exp_ack);
        bclk = ~bclk; #1;
        chk({ctx, " R9 busclk"}, bclk_o, bclk);
    endtask

    task automatic reach(input int s);
        stop_n = 1; sleep_n = 1; reset_n = 0;
        step(4);
        reset_n = 1;
        step(4);
        if (s >= 1) begin stop_n = 0; step(5); end
        if (s == 2) begin sleep_n = 0; step(5); end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        step(3);
        check_state("reset R11", 0, 0);
        rst = 0;
        step(2);

        // exhaustive sweep: start state x all pin combinations
        for (int s = 0; s < 3; s++) begin
            for (int c = 0; c < 8; c++) begin
                string ctx;
                int n1, n2;
                reach(s);
                check_state($sformatf("start s%0d", s), s, 0);
                stop_n = c[0]; sleep_n = c[1]; reset_n = c[2];
                n1 = model(s, c[0], c[1], c[2]);
                n2 = model(n1, c[0], c[1], c[2]);
                ctx = $sformatf("s%0d pins%0d", s, c);
                step(2);
                // R10: no effect before the third edge
                check_state({ctx, " R10 edge2"}, s, 0);
                step(1);
                // R4 R7 R11 R14 covered by the model outcome
                check_state({ctx, " edge3"}, n1, s == 0 && n1 == 1);
                step(1);
                // R12: one cycle in grant on the way out of sleep
                check_state({ctx, " R12 edge4"}, n2, n1 == 0 && n2 == 1);
            end
        end

        // synchronous rst from Sleep (R11)
        reach(2);
        rst = 1;
        step(1);
        check_state("rst R11", 0, 0);
        rst = 0;
        stop_n = 1; sleep_n = 1;
        step(4);
        check_state("after rst R11", 0, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule